// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

This block is a single-channel event timer on a simple 32-bit register bus. Software writes a start value as two 32-bit halves. It picks a 32-bit or 64-bit count and a one-shot or repeating mode. Setting the run bit starts the count. The counter steps down by one per clock. When it sits at zero for a cycle, the block records an expiry event. In repeating mode the counter then refills from the start value. In one-shot mode it parks at zero.

An expiry sets a sticky pending flag. A write-one-to-clear bit clears it. The interrupt pin follows the pending flag gated by a software enable. The live count can be read two ways. The first is a pair of plain live windows. The second is a low/high pair in which reading the low half freezes the matching high half, so the two halves come from the same cycle.

All bus reads are registered. A read strobe in one cycle returns data after the next clock edge.

Top module: `evt_timer`

## Requirements
- R1: After synchronous reset every register reads zero, the interrupt pin is low and the counter is stopped.
- R2: Writable fields read back at their positions. The start-value halves are at 0x00 (low) and 0x04 (high). At control 0x10, bit 0 = repeat mode, bit 1 = run and bit 16 = 64-bit width. At interrupt register 0x14, bit 0 = interrupt enable. Every other control bit reads zero.
- R3: A control write that sets the run bit while the timer is stopped loads the counter with the start value. In 32-bit width this is the low half with the high half forced to zero.
- R4: While running, the count drops by one per cycle. With start value L, the pending flag (interrupt bit 1) first sets at the edge L+1 cycles after the start edge.
- R5: In repeat mode an expiry refills the counter from the start value and counting goes on, giving an expiry every L+1 cycles.
- R6: In one-shot mode the counter holds zero after its expiry and raises no further event until a stop/start pair restarts it.
- R7: In 64-bit width, the low and high halves count as one 64-bit value, with a borrow from low to high.
- R8: In 32-bit width the high half of the count stays zero (live window 0x1C and latched window 0x0C) whatever the high start half holds.
- R9: Writing 1 to interrupt bit 3 clears the pending flag. Bit 3 always reads zero. An expiry in the same cycle wins over the clear.
- R10: Interrupt bit 2 reads the pending flag AND the enable, and the interrupt pin carries that same value.
- R11: While stopped the count is frozen and start-value writes do not change it. The new start value takes effect at the next start.
- R12: A read of the count low half at 0x08 captures the high half, which a later read of 0x0C returns. The windows 0x18 (low) and 0x1C (high) always return the live count.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid after the edge that takes the read strobe |
| irq_o | output | 1 | Registered interrupt, pending AND enable |

## Verification
- **Reads:** read data is due on the cycle after the read strobe. It shows the count held just before the sampling edge.
- **Count values:** with the start write taken at edge S, a read taken at edge S+k sees L-(k-1). In repeat mode the step count is taken modulo L+1; in one-shot mode the value floors at zero.
- **Interrupt pin:** the pin is due at edge S+L+1, in the same edge as the pending flag.
- **How the bench keeps to this:** it counts every edge it drives and derives each expected value from that count. It samples only at falling edges, so it never reads a value in the cycle it changes.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam int A_START_LO = 'h00;
  localparam int A_START_HI = 'h04;
  localparam int A_CNT_LO   = 'h08;
  localparam int A_CNT_HI   = 'h0C;
  localparam int A_CTRL     = 'h10;
  localparam int A_IRQ      = 'h14;
  localparam int A_LIVE_LO  = 'h18;
  localparam int A_LIVE_HI  = 'h1C;

  localparam int CB_REPEAT = 0;
  localparam int CB_RUN    = 1;
  localparam int CB_WIDE   = 16;

  localparam int IB_EN     = 0;
  localparam int IB_RAW    = 1;
  localparam int IB_MASKED = 2;
  localparam int IB_CLR    = 3;

  typedef struct packed {
    logic repeat_md;
    logic run;
    logic wide;
  } ctrl_t;
endpackage

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_wide,
  input  logic          run,
  input  logic          wide,
  input  logic          repeat_md,
  input  logic [DW-1:0] ld_lo,
  input  logic [DW-1:0] ld_hi,
  output logic [CW-1:0] count,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [CW-1:0] full_val, narrow_val, refill;
  logic          at_zero;

  assign full_val   = {ld_hi, ld_lo};
  assign narrow_val = {{DW{1'b0}}, ld_lo};
  assign refill     = wide ? full_val : narrow_val;
  assign at_zero    = wide ? (cnt_q == '0) : (cnt_q[DW-1:0] == '0);
  assign expire     = run && !done_q && at_zero && !start;
  assign count      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= start_wide ? full_val : narrow_val;
      done_q <= 1'b0;
    end else if (expire) begin
      if (repeat_md) cnt_q <= refill;
      else           done_q <= 1'b1;
    end else if (run && !done_q) begin
      if (wide) cnt_q <= cnt_q - 1'b1;
      else      cnt_q <= {cnt_q[CW-1:DW], cnt_q[DW-1:0] - 1'b1};
    end
  end

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == (($past(start_wide)) ? $past(full_val) : $past(narrow_val)));
  // R5
  repeat_refill_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && repeat_md) |=> cnt_q == $past(refill));
  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> $stable(cnt_q) && !expire);
  // R8
  narrow_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wide && !start && !expire) |=> $stable(cnt_q[CW-1:DW]));
  // R11
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic wr_irq,
  input  logic wr_en_bit,
  input  logic wr_clr_bit,
  input  logic expire,
  output logic ien,
  output logic raw,
  output logic irq_o
);
  logic ien_q, raw_q, irq_q;
  logic ien_n, raw_n;

  always_comb begin
    ien_n = wr_irq ? wr_en_bit : ien_q;
    raw_n = raw_q;
    if (wr_irq && wr_clr_bit) raw_n = 1'b0;
    if (expire)               raw_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
      raw_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ien_q <= ien_n;
      raw_q <= raw_n;
      irq_q <= raw_n & ien_n;
    end
  end

  assign ien   = ien_q;
  assign raw   = raw_q;
  assign irq_o = irq_q;

  // R4
  expire_sets_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> raw_q);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_irq && wr_clr_bit && !expire) |=> !raw_q);
  // R10
  pin_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (raw_q && ien_q));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  logic [DW-1:0] ld_lo_q, ld_hi_q, hold_q, rdata_q;
  ctrl_t         ctrl_q;
  logic [CW-1:0] count;
  logic          expire, start, ien, raw;
  logic          wr_ctrl, wr_irq;

  assign wr_ctrl = bus_we && (bus_addr == AW'(A_CTRL));
  assign wr_irq  = bus_we && (bus_addr == AW'(A_IRQ));
  assign start   = wr_ctrl && bus_wdata[CB_RUN] && !ctrl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_lo_q <= '0;
      ld_hi_q <= '0;
      ctrl_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_START_LO)) ld_lo_q <= bus_wdata;
      if (bus_addr == AW'(A_START_HI)) ld_hi_q <= bus_wdata;
      if (wr_ctrl) begin
        ctrl_q.repeat_md <= bus_wdata[CB_REPEAT];
        ctrl_q.run       <= bus_wdata[CB_RUN];
        ctrl_q.wide      <= bus_wdata[CB_WIDE];
      end
    end
  end

  evt_timer_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst),
    .start(start), .start_wide(bus_wdata[CB_WIDE]),
    .run(ctrl_q.run), .wide(ctrl_q.wide), .repeat_md(ctrl_q.repeat_md),
    .ld_lo(ld_lo_q), .ld_hi(ld_hi_q),
    .count(count), .expire(expire)
  );

  evt_timer_irq u_irq (
    .clk(clk), .rst(rst),
    .wr_irq(wr_irq), .wr_en_bit(bus_wdata[IB_EN]), .wr_clr_bit(bus_wdata[IB_CLR]),
    .expire(expire),
    .ien(ien), .raw(raw), .irq_o(irq_o)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      A_START_LO: rd_mux = ld_lo_q;
      A_START_HI: rd_mux = ld_hi_q;
      A_CNT_LO:   rd_mux = count[DW-1:0];
      A_CNT_HI:   rd_mux = hold_q;
      A_CTRL: begin
        rd_mux[CB_REPEAT] = ctrl_q.repeat_md;
        rd_mux[CB_RUN]    = ctrl_q.run;
        rd_mux[CB_WIDE]   = ctrl_q.wide;
      end
      A_IRQ: begin
        rd_mux[IB_EN]     = ien;
        rd_mux[IB_RAW]    = raw;
        rd_mux[IB_MASKED] = raw & ien;
      end
      A_LIVE_LO:  rd_mux = count[DW-1:0];
      A_LIVE_HI:  rd_mux = count[CW-1:DW];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      hold_q  <= '0;
    end else if (bus_re) begin
      rdata_q <= rd_mux;
      if (bus_addr == AW'(A_CNT_LO)) hold_q <= count[CW-1:DW];
    end
  end

  assign bus_rdata = rdata_q;

  // R12
  hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == AW'(A_CNT_LO)) |=> hold_q == $past(count[CW-1:DW]));
  // R2
  run_bit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ctrl_q.run == $past(bus_wdata[CB_RUN]));
endmodule

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  evt_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [31:0] C_REP = 32'h1, C_RUN = 32'h2, C_WIDE = 32'h10000;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    edges++;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    tick();
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic longint unsigned model_cnt(longint unsigned l, int k, bit rep);
    longint unsigned j = longint'(k - 1);
    if (rep) return l - (j % (l + 1));
    return (j >= l) ? 64'd0 : l - j;
  endfunction

  function automatic bit model_raw(longint unsigned l, int k);
    return longint'(k - 1) >= l + 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int s;
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    void'($urandom(32'd2024));
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d);
      chk(d == 0, "R1 reset read", d, 0);
    end
    chk(irq_o == 0, "R1 irq low", irq_o, 0);

    // R2 readback
    wr(5'h00, 32'h1234_5678); wr(5'h04, 32'h9ABC_DEF0);
    rd(5'h00, d); chk(d == 32'h1234_5678, "R2 start lo", d, 32'h1234_5678);
    rd(5'h04, d); chk(d == 32'h9ABC_DEF0, "R2 start hi", d, 32'h9ABC_DEF0);
    wr(5'h10, C_WIDE | C_REP);
    rd(5'h10, d); chk(d == 32'h10001, "R2 ctrl", d, 32'h10001);
    wr(5'h10, 32'hFFFF_FFFC);
    rd(5'h10, d); chk(d == 32'h10000, "R2 ctrl unused bits", d, 32'h10000);
    wr(5'h10, 0);
    wr(5'h14, 32'h1);
    rd(5'h14, d); chk(d == 32'h1, "R2 irq enable", d, 1);
    wr(5'h14, 32'h0);

    // R3 / R8 / R12 32-bit start with nonzero high half
    wr(5'h00, 100); wr(5'h04, 32'hDEAD);
    wr(5'h10, C_RUN | C_REP); s = edges;
    rd(5'h08, d); chk(d == 100, "R3 narrow start", d, 100);
    rd(5'h0C, d); chk(d == 0, "R8 latched hi zero", d, 0);
    rd(5'h1C, d); chk(d == 0, "R8 live hi zero", d, 0);
    rd(5'h18, d); chk(d == 32'(model_cnt(100, edges - s, 1)), "R12 live lo", d, model_cnt(100, edges - s, 1));

    // R11 frozen while stopped, new start value used on restart
    wr(5'h10, 0);
    rd(5'h18, d); idle(5); rd(5'h18, d2);
    chk(d == d2, "R11 frozen", d2, d);
    wr(5'h00, 7);
    rd(5'h18, d2); chk(d == d2, "R11 load while stopped", d2, d);
    wr(5'h10, C_RUN);
    rd(5'h08, d); chk(d == 7, "R11 restart from new value", d, 7);

    // R6 / R9 / R10 one-shot with interrupt masked
    wr(5'h10, 0); wr(5'h14, 32'h8); wr(5'h00, 3);
    wr(5'h10, C_RUN); idle(10);
    rd(5'h14, d); chk(d == 32'h2, "R10 raw set, masked clear", d, 2);
    chk(irq_o == 0, "R10 pin low while masked", irq_o, 0);
    wr(5'h14, 32'h8);
    rd(5'h14, d); chk(d == 0, "R9 clear and bit3 reads zero", d, 0);
    idle(10);
    rd(5'h14, d); chk(d == 0, "R6 no second event", d, 0);
    rd(5'h18, d); chk(d == 0, "R6 holds zero", d, 0);
    wr(5'h14, 32'h1);
    chk(irq_o == 0, "R10 enable with nothing pending", irq_o, 0);
    wr(5'h10, 0); wr(5'h10, C_RUN); idle(6);
    rd(5'h14, d); chk(d == 32'h7, "R6 restart gives event", d, 7);
    chk(irq_o == 1, "R10 pin high", irq_o, 1);

    // R4 / R5 / R9 repeat-mode timing on the pin
    wr(5'h10, 0); wr(5'h14, 32'h9); wr(5'h00, 4);
    wr(5'h10, C_RUN | C_REP); s = edges;
    while (edges < s + 4) tick();
    chk(irq_o == 0, "R4 not yet expired", irq_o, 0);
    tick();
    chk(irq_o == 1, "R4 expiry at L+1", irq_o, 1);
    wr(5'h14, 32'h9);
    chk(irq_o == 0, "R9 pin cleared", irq_o, 0);
    while (edges < s + 9) tick();
    chk(irq_o == 0, "R5 before second expiry", irq_o, 0);
    tick();
    chk(irq_o == 1, "R5 second expiry", irq_o, 1);

    // R7 / R12 64-bit borrow and coherent latch
    wr(5'h10, 0); wr(5'h14, 32'h8);
    wr(5'h00, 1); wr(5'h04, 1);
    wr(5'h10, C_RUN | C_WIDE);
    rd(5'h08, d); chk(d == 1, "R7 lo start", d, 1);
    rd(5'h0C, d); chk(d == 1, "R7 hi start", d, 1);
    rd(5'h08, d); chk(d == 32'hFFFF_FFFF, "R7 borrow lo", d, 32'hFFFF_FFFF);
    rd(5'h0C, d); chk(d == 0, "R7 borrow hi", d, 0);
    wr(5'h10, 0);
    wr(5'h00, 2); wr(5'h04, 1);
    wr(5'h10, C_RUN | C_WIDE);
    rd(5'h08, d); chk(d == 2, "R12 lo capture", d, 2);
    idle(4);
    rd(5'h1C, d); chk(d == 0, "R12 live hi", d, 0);
    rd(5'h0C, d); chk(d == 1, "R12 latched hi", d, 1);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [31:0] lo, hi;
      bit w, rp, ie, rw;
      longint unsigned l, m;
      int k;
      lo = $urandom_range(1, 60);
      hi = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2) : 0;
      w = 1'($urandom_range(0, 1)); rp = 1'($urandom_range(0, 1)); ie = 1'($urandom_range(0, 1));
      l = w ? {hi, lo} : {32'h0, lo};
      wr(5'h10, 0); wr(5'h14, {28'h0, 4'h8} | 32'(ie));
      wr(5'h00, lo); wr(5'h04, hi);
      wr(5'h10, C_RUN | (rp ? C_REP : 0) | (w ? C_WIDE : 0)); s = edges;
      idle($urandom_range(0, 90));
      rd(5'h08, d); k = edges - s; m = model_cnt(l, k, rp);
      chk(d == m[31:0], "R4 random count lo", d, m[31:0]);
      rd(5'h0C, d); chk(d == m[63:32], "R7 random count hi", d, m[63:32]);
      rd(5'h14, d); rw = model_raw(l, edges - s);
      chk(d == {29'h0, rw & ie, rw, ie}, "R10 random irq reg", d, {29'h0, rw & ie, rw, ie});
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule